// File: doc/BRIEF.md
# Timer Interrupt Router with Message Delivery

This block is the interrupt delivery stage of a multi-timer event peripheral. A pulse on `timerFire[t]` means comparator `t` has matched. Each timer's configuration decides where that event goes. It can set a status bit and hold a wired interrupt line high (level mode). It can pulse a wired line for one cycle (edge mode). When message delivery is enabled, it can instead bypass the wired lines and issue one posted 32-bit memory write toward the bus.

Each timer holds a 64-bit route register. The data word of the message sits in its lower half and the target address in its upper half. Software reaches all registers through a 32-bit interface: writes are strobed, and reads are combinational from the address. The main counter, comparator arithmetic and periodic reload sit outside this block. Message-delivery support is a build-time parameter that is off by default.

Top module: `tmr_msg_router`

## Requirements
- R1: After reset, each timer's config low word reads 0x30 (bit 4 periodic-capable, bit 5 64-bit-capable), plus bit 15 (message-capable) only when MSI_EN=1. The config high word reads 0x4 (bit 34 set). Both comparator halves read 0xFFFFFFFF. The route halves, global config (0x010) and status (0x020) read 0. All lines are low and `msgValid` is low.
- R2: Timer t's register group starts at 0x100+0x20*t. Within it: config low at 0x00, config high at 0x04, comparator halves at 0x08/0x0C, route data (low half) at 0x10, route address (high half) at 0x14. Writing one 32-bit half leaves the other half unchanged.
- R3: Only config bits 1 (level mode), 2 (interrupt enable), 13:9 (line select) and 14 (message enable, only when MSI_EN=1) are writable. Capability bits and the whole config high word ignore writes.
- R4: In level mode, with message delivery off and both global enable (bit 0 at 0x010) and interrupt enable set, a fire sets status bit t and raises `irqLines[sel]` on the following cycle.
- R5: In edge mode with message delivery off and both enables set, a fire raises `irqLines[sel]` for exactly one cycle and leaves the status unchanged.
- R6: A fire while global enable or interrupt enable is clear produces no line, no message and no status bit, and it clears status bit t.
- R7: With both enables and message enable set, a fire raises `msgValid` on the next cycle. `msgAddr` then carries route[63:32] and `msgData` carries route[31:0]. Exactly one transfer results, and the status and lines are untouched.
- R8: `msgValid` and the selected timer stay put until `msgReady`. When several timers are pending, the lowest index is sent first.
- R9: A fire for a timer whose write is still pending, including in the cycle it is accepted, is merged and adds no transfer.
- R10: Writing 1 to bit t of the status register (0x020) clears status bit t, and the line it drove falls.
- R11: A config write that turns message enable from 0 to 1 clears that timer's status bit, so its line falls on the same update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| timerFire | input | NUM_TIMERS | Comparator match pulse, one per timer |
| irqLines | output | NUM_LINES | Wired interrupt lines |
| msgValid | output | 1 | Message write request valid |
| msgReady | input | 1 | Bus accepts the message write |
| msgAddr | output | 32 | Message target address |
| msgData | output | 32 | Message data word |

## Verification
A register write takes effect at the clock edge on which the strobe is sampled. Reads are combinational, so the bench reads back just after that edge. A fire pulse moves status, level lines and `msgValid` one edge later. An edge-mode line is high for that single cycle and low after the next edge. The bench therefore drives every input on the falling edge and samples on the following falling edge, which falls exactly one register stage after the stimulus. Transfers are counted on each rising edge where valid and ready are both high, so merge and ordering checks compare the logged transfers against expected data words.

// File: rtl/tmr_route_pkg.sv
package tmr_route_pkg;
  localparam int TMR_MAX   = 8;
  localparam int TMR_IDX_W = 3;

  // config bit positions
  localparam int CFG_LEVEL   = 1;
  localparam int CFG_INTEN   = 2;
  localparam int CFG_PERCAP  = 4;
  localparam int CFG_SIZECAP = 5;
  localparam int CFG_RTLO    = 9;
  localparam int CFG_RTHI    = 13;
  localparam int CFG_MSIEN   = 14;
  localparam int CFG_MSICAP  = 15;

  // address map
  localparam int OFS_GLB    = 'h010;
  localparam int OFS_STS    = 'h020;
  localparam int OFS_GRP0   = 'h100;
  localparam int GRP_STRIDE = 'h020;

  typedef enum logic [2:0] {
    REG_CFG, REG_CMPLO, REG_CMPHI, REG_RTLO, REG_RTHI
  } tmrReg_e;

  typedef struct packed {
    logic                 glbWr;
    logic                 stsWr;
    logic                 tmrWr;
    logic [TMR_IDX_W-1:0] tmrIdx;
    tmrReg_e              tmrReg;
  } regStrobe_t;
endpackage

// File: rtl/tmr_route_ctrl.sv
module tmr_route_ctrl
  import tmr_route_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [NUM_TIMERS-1:0] msiFire,
  input  logic                  msgReady,
  output regStrobe_t            strb,
  output logic                  msgValid,
  output logic [IDX_W-1:0]      msgSel
);
  function automatic logic [ADDR_W-6:0] grpTag(int t);
    return (ADDR_W-5)'((OFS_GRP0 + t * GRP_STRIDE) >> 5);
  endfunction

  // write decode into strobes
  always_comb begin
    strb = '0;
    strb.tmrReg = REG_CFG;
    if (regWrEn) begin
      if (regAddr == ADDR_W'(OFS_GLB)) strb.glbWr = 1'b1;
      if (regAddr == ADDR_W'(OFS_STS)) strb.stsWr = 1'b1;
      for (int t = 0; t < NUM_TIMERS; t++) begin
        if (regAddr[ADDR_W-1:5] == grpTag(t)) begin
          strb.tmrIdx = TMR_IDX_W'(t);
          strb.tmrWr  = 1'b1;
          case (regAddr[4:0])
            5'h00:   strb.tmrReg = REG_CFG;
            5'h08:   strb.tmrReg = REG_CMPLO;
            5'h0C:   strb.tmrReg = REG_CMPHI;
            5'h10:   strb.tmrReg = REG_RTLO;
            5'h14:   strb.tmrReg = REG_RTHI;
            default: strb.tmrWr  = 1'b0;   // config high word is read-only
          endcase
        end
      end
    end
  end

  // message pending state and selection
  logic [NUM_TIMERS-1:0] pend;
  logic                  busy;
  logic [IDX_W-1:0]      curIdx, lowIdx, selIdx;
  logic                  accept;

  always_comb begin
    lowIdx = '0;
    for (int t = NUM_TIMERS - 1; t >= 0; t--)
      if (pend[t]) lowIdx = IDX_W'(t);
  end

  assign selIdx   = busy ? curIdx : lowIdx;
  assign msgSel   = selIdx;
  assign msgValid = |pend;
  assign accept   = msgValid && msgReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= '0;
      busy   <= 1'b0;
      curIdx <= '0;
    end else begin
      for (int t = 0; t < NUM_TIMERS; t++)
        pend[t] <= pend[t] ? !(accept && selIdx == IDX_W'(t)) : msiFire[t];
      busy   <= msgValid && !msgReady;
      curIdx <= selIdx;
    end
  end

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> msgValid);
  assert_hold_sel_R8: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> $stable(msgSel));
  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones($past(pend) & ~pend) <= 1);
endmodule

// File: rtl/tmr_route_dp.sv
module tmr_route_dp
  import tmr_route_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_LINES  = 32,
  parameter int ADDR_W     = 12,
  parameter bit MSI_EN     = 1'b0,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [31:0]           regWrData,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [NUM_TIMERS-1:0] timerFire,
  input  logic [IDX_W-1:0]      msgSel,
  output logic [31:0]           regRdData,
  output logic [NUM_LINES-1:0]  irqLines,
  output logic [NUM_TIMERS-1:0] msiFire,
  output logic [31:0]           msgAddr,
  output logic [31:0]           msgData
);
  localparam logic [31:0] WR_MASK = (32'(1) << CFG_LEVEL) | (32'(1) << CFG_INTEN)
                                  | (32'h1F << CFG_RTLO)
                                  | (MSI_EN ? (32'(1) << CFG_MSIEN) : 32'h0);
  localparam logic [31:0] CAP_BITS = (32'(1) << CFG_PERCAP) | (32'(1) << CFG_SIZECAP)
                                   | (MSI_EN ? (32'(1) << CFG_MSICAP) : 32'h0);
  localparam logic [31:0] CFG_HI_RO = 32'h0000_0004;

  logic [31:0] cfgW   [NUM_TIMERS];
  logic [63:0] cmpR   [NUM_TIMERS];
  logic [63:0] routeR [NUM_TIMERS];
  logic        glbEn;
  logic [NUM_TIMERS-1:0] status, edgePulse, intOk, msiOn, levelOn, msiRise, stsClr;

  function automatic logic wrHit(int t, tmrReg_e r);
    return strb.tmrWr && strb.tmrIdx == TMR_IDX_W'(t) && strb.tmrReg == r;
  endfunction

  function automatic logic [ADDR_W-6:0] grpTag(int t);
    return (ADDR_W-5)'((OFS_GRP0 + t * GRP_STRIDE) >> 5);
  endfunction

  always_comb begin
    for (int t = 0; t < NUM_TIMERS; t++) begin
      intOk[t]   = glbEn && cfgW[t][CFG_INTEN];
      msiOn[t]   = cfgW[t][CFG_MSIEN];
      levelOn[t] = cfgW[t][CFG_LEVEL];
      msiFire[t] = timerFire[t] && intOk[t] && msiOn[t];
      msiRise[t] = wrHit(t, REG_CFG) && !msiOn[t] && regWrData[CFG_MSIEN] && WR_MASK[CFG_MSIEN];
      stsClr[t]  = (timerFire[t] && !intOk[t]) || msiRise[t] || (strb.stsWr && regWrData[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) glbEn <= 1'b0;
    else if (strb.glbWr) glbEn <= regWrData[0];
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (!rstN) begin
        cfgW[t]      <= '0;
        cmpR[t]      <= '1;
        routeR[t]    <= '0;
        status[t]    <= 1'b0;
        edgePulse[t] <= 1'b0;
      end else begin
        if (wrHit(t, REG_CFG))   cfgW[t]          <= regWrData & WR_MASK;
        if (wrHit(t, REG_CMPLO)) cmpR[t][31:0]    <= regWrData;
        if (wrHit(t, REG_CMPHI)) cmpR[t][63:32]   <= regWrData;
        if (wrHit(t, REG_RTLO))  routeR[t][31:0]  <= regWrData;
        if (wrHit(t, REG_RTHI))  routeR[t][63:32] <= regWrData;
        edgePulse[t] <= timerFire[t] && intOk[t] && !msiOn[t] && !levelOn[t];
        if (stsClr[t])
          status[t] <= 1'b0;
        else if (timerFire[t] && intOk[t] && !msiOn[t] && levelOn[t])
          status[t] <= 1'b1;
      end
    end
  end

  // wired lines: OR of every timer that selects the line
  always_comb begin
    irqLines = '0;
    for (int l = 0; l < NUM_LINES; l++)
      for (int t = 0; t < NUM_TIMERS; t++)
        if (!msiOn[t] && (status[t] || edgePulse[t]) && cfgW[t][CFG_RTHI:CFG_RTLO] == 5'(l))
          irqLines[l] = 1'b1;
  end

  assign msgAddr = routeR[msgSel][63:32];
  assign msgData = routeR[msgSel][31:0];

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFS_GLB)) regRdData[0] = glbEn;
    if (regAddr == ADDR_W'(OFS_STS)) regRdData = 32'(status);
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (regAddr[ADDR_W-1:5] == grpTag(t)) begin
        case (regAddr[4:0])
          5'h00:   regRdData = cfgW[t] | CAP_BITS;
          5'h04:   regRdData = CFG_HI_RO;
          5'h08:   regRdData = cmpR[t][31:0];
          5'h0C:   regRdData = cmpR[t][63:32];
          5'h10:   regRdData = routeR[t][31:0];
          5'h14:   regRdData = routeR[t][63:32];
          default: regRdData = '0;
        endcase
      end
    end
  end

  for (genvar ga = 0; ga < NUM_TIMERS; ga++) begin : g_chk
    assert_no_status_in_msg_R11: assert property (@(posedge clk) disable iff (!rstN)
      !(status[ga] && msiOn[ga]));
    assert_status_source_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[ga]) |-> $past(timerFire[ga]));
    assert_edge_no_status_R5: assert property (@(posedge clk) disable iff (!rstN)
      edgePulse[ga] |-> !$rose(status[ga]));
  end
endmodule

// File: rtl/tmr_msg_router.sv
module tmr_msg_router
  import tmr_route_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_LINES  = 32,
  parameter int ADDR_W     = 12,
  parameter bit MSI_EN     = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic [NUM_TIMERS-1:0] timerFire,
  output logic [NUM_LINES-1:0]  irqLines,
  output logic                  msgValid,
  input  logic                  msgReady,
  output logic [31:0]           msgAddr,
  output logic [31:0]           msgData
);
  localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

  regStrobe_t            strb;
  logic [NUM_TIMERS-1:0] msiFire;
  logic [IDX_W-1:0]      msgSel;

  tmr_route_ctrl #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .msiFire(msiFire), .msgReady(msgReady), .strb(strb),
    .msgValid(msgValid), .msgSel(msgSel)
  );

  tmr_route_dp #(.NUM_TIMERS(NUM_TIMERS), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
                 .MSI_EN(MSI_EN), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData), .regAddr(regAddr),
    .timerFire(timerFire), .msgSel(msgSel), .regRdData(regRdData),
    .irqLines(irqLines), .msiFire(msiFire), .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: tb/sim_tmr_msg_router.sv
`timescale 1ns/1ps
module sim_tmr_msg_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdData, rdData1;
  logic [2:0]  timerFire = '0;
  logic [31:0] irqLines, irqLines1;
  logic        msgValid, msgValid1;
  logic        msgReady = 1'b0;
  logic [31:0] msgAddr, msgData, msgAddr1, msgData1;

  int checks = 0;
  int errors = 0;
  int xferCount = 0;
  logic [31:0] xferData [16];
  logic [31:0] xferAddr [16];
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_msg_router #(.NUM_TIMERS(3), .MSI_EN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rdData), .timerFire(timerFire), .irqLines(irqLines), .msgValid(msgValid),
    .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  tmr_msg_router u1 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(1'b0), .regWrData(32'h0),
    .regRdData(rdData1), .timerFire(3'b000), .irqLines(irqLines1), .msgValid(msgValid1),
    .msgReady(1'b0), .msgAddr(msgAddr1), .msgData(msgData1)
  );

  always @(posedge clk) begin
    if (rstN && msgValid && msgReady && xferCount < 16) begin
      xferData[xferCount] = msgData;
      xferAddr[xferCount] = msgAddr;
      xferCount = xferCount + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic fire(input logic [2:0] m);
    @(negedge clk);
    timerFire = m;
    @(negedge clk);
    timerFire = '0;
  endtask

  task automatic readyPulse(input int n);
    @(negedge clk);
    msgReady = 1'b1;
    repeat (n) @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h100, d); chk("R1 cfg lo msi build", d, 32'h8030);
    chk("R1 cfg lo default build", rdData1, 32'h30);
    rd(12'h104, d); chk("R1 cfg hi", d, 32'h4);
    rd(12'h148, d); chk("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(12'h14C, d); chk("R1 cmp hi", d, 32'hFFFF_FFFF);
    rd(12'h130, d); chk("R1 route lo", d, 32'h0);
    rd(12'h010, d); chk("R1 global", d, 32'h0);
    rd(12'h020, d); chk("R1 status", d, 32'h0);
    chk("R1 lines", irqLines, 32'h0);
    chk("R1 msgValid", msgValid, 1'b0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(12'h130, 32'hDEAD_BEEF);
    wr(12'h134, 32'h1234_5678);
    rd(12'h130, d); chk("R2 route lo kept", d, 32'hDEAD_BEEF);
    rd(12'h134, d); chk("R2 route hi", d, 32'h1234_5678);
    wr(12'h128, 32'h5);
    rd(12'h128, d); chk("R2 cmp lo", d, 32'h5);
    rd(12'h12C, d); chk("R2 cmp hi kept", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr(12'h140, 32'hFFFF_FFFF);
    rd(12'h140, d); chk("R3 cfg writable mask", d, 32'hFE36);
    wr(12'h144, 32'hFFFF_FFFF);
    rd(12'h144, d); chk("R3 cfg hi read-only", d, 32'h4);
    wr(12'h140, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(12'h010, 32'h1);
    wr(12'h100, 32'h606);
    fire(3'b001);
    rd(12'h020, d); chk("R4 status set", d, 32'h1);
    chk("R4 line raised", irqLines, 32'h8);
    wr(12'h020, 32'h1);
    rd(12'h020, d); chk("R10 status cleared", d, 32'h0);
    chk("R10 line dropped", irqLines, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(12'h120, 32'hE04);
    fire(3'b010);
    chk("R5 edge line high", irqLines, 32'h80);
    rd(12'h020, d); chk("R5 no status", d, 32'h0);
    @(negedge clk);
    chk("R5 edge line one cycle", irqLines, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    fire(3'b001);
    rd(12'h020, d); chk("R6 setup status", d, 32'h1);
    wr(12'h100, 32'h602);
    fire(3'b001);
    rd(12'h020, d); chk("R6 int disabled clears status", d, 32'h0);
    chk("R6 int disabled no line", irqLines, 32'h0);
    wr(12'h100, 32'h606);
    wr(12'h010, 32'h0);
    fire(3'b001);
    rd(12'h020, d); chk("R6 global disabled no status", d, 32'h0);
    chk("R6 global disabled no msg", msgValid, 1'b0);
    wr(12'h010, 32'h1);
  endtask

  task automatic t_msg;
    logic [31:0] d;
    int base;
    wr(12'h110, 32'h0000_A5A5);
    wr(12'h114, 32'hFEE0_0000);
    fire(3'b001);
    chk("R11 setup line", irqLines, 32'h8);
    wr(12'h100, 32'h4606);
    rd(12'h020, d); chk("R11 status cleared on msg enable", d, 32'h0);
    chk("R11 line dropped", irqLines, 32'h0);
    base = xferCount;
    fire(3'b001);
    chk("R7 msgValid", msgValid, 1'b1);
    chk("R7 msgAddr", msgAddr, 32'hFEE0_0000);
    chk("R7 msgData", msgData, 32'h0000_A5A5);
    chk("R7 no line", irqLines, 32'h0);
    rd(12'h020, d); chk("R7 no status", d, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 valid held", msgValid, 1'b1);
    fire(3'b001);
    readyPulse(1);
    chk("R9 drained", msgValid, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 one transfer", xferCount - base, 1);
    chk("R7 transfer data", xferData[base], 32'h0000_A5A5);
  endtask

  task automatic t_priority;
    int base;
    wr(12'h130, 32'h11);
    wr(12'h134, 32'h1000);
    wr(12'h150, 32'h22);
    wr(12'h154, 32'h2000);
    wr(12'h120, 32'h4004);
    wr(12'h140, 32'h4004);
    base = xferCount;
    fire(3'b110);
    chk("R8 lowest selected", msgData, 32'h11);
    readyPulse(2);
    chk("R8 two transfers", xferCount - base, 2);
    chk("R8 first data", xferData[base], 32'h11);
    chk("R8 second addr", xferAddr[base+1], 32'h2000);
    chk("R8 idle after", msgValid, 1'b0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_map;
    t_readonly;
    t_level;
    t_edge;
    t_disabled;
    t_msg;
    t_priority;
    finishRun;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun;
  end
endmodule